// File: doc/BRIEF.md
# Utilization Frequency Governor

This block watches a per-cycle busy indication from a processor and, once per sampling window, picks a performance level for the clock generator. Each level is an index into a small table of frequency steps, with index 0 the slowest and the top index the fastest. Within each window the block counts how many sampled cycles were busy. When the window closes, it compares that count against a programmable fraction of the window length.

The policy is deliberately lopsided. A window whose busy share is above the threshold sends the level straight to the fastest step. Any other window lowers the level by exactly one step, and the level stops at the slowest step. The comparison uses two integer products, so the block needs no divider. The window length and the threshold are captured once at the start of each window, so software can retune them at any time without disturbing a window that is already running. A one-cycle strobe marks each cycle in which the level index has just changed, so the downstream clock logic only has to react on those edges.

Top module: `util_freq_governor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `level_o` equals NUM_LEVELS-1 and `level_chg_o` is 0.
- R2: A window is a run of L consecutive rising clock edges. Each edge samples `busy_i` once. L is the value of `win_len_i` taken at the window's first edge, and a value of 0 is treated as 1. The first window starts at the first edge after reset is released, and each later window starts at the edge right after the previous window's last edge. `level_o` changes only on the last edge of a window.
- R3: At the last edge of a window, if busy_count × 100 > pct × L, where pct is `thresh_pct_i` taken at the window's first edge, `level_o` becomes NUM_LEVELS-1.
- R4: At the last edge of a window, if busy_count × 100 ≤ pct × L and `level_o` is above 0, `level_o` drops by exactly one. An exact tie counts as not above the threshold.
- R5: At the last edge of a window that is not above the threshold, a `level_o` of 0 stays 0.
- R6: `level_chg_o` is 1 for exactly the one cycle after an edge at which `level_o` took a new value, and 0 at all other times.
- R7: Changes to `win_len_i` and `thresh_pct_i` after a window's first edge have no effect on that window's length or decision.
- R8: The busy count starts from zero in every window. Busy cycles from one window never count toward the next, and the busy count never exceeds the number of edges sampled so far in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Processor busy in this cycle |
| win_len_i | input | WIN_W | Sampling window length in cycles (0 means 1) |
| thresh_pct_i | input | PCT_W | Up-threshold in percent of the window |
| level_o | output | $clog2(NUM_LEVELS) | Selected frequency-level index, 0 is slowest |
| level_chg_o | output | 1 | One-cycle pulse after the level index changes |

## Verification
The bench targets the exact tie between busy share and threshold. A design that compares with greater-or-equal would jump to the top level where it should step down. It also walks the level down to the floor and then adds one more idle window, which catches an index that wraps from zero to the top or a strobe that fires with no change. Window length and threshold are disturbed in the middle of windows, which exposes a design that reads them live rather than capturing them. An all-busy window followed by an all-idle window catches counters that are not cleared between windows. A zero window length is also applied, to catch a window that never closes.

// File: rtl/fgov_pkg.sv
package fgov_pkg;
  localparam int unsigned PCT_SCALE   = 100;
  localparam int unsigned PCT_SCALE_W = 7;

  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_JUMP  = 2'd1,
    DEC_STEP  = 2'd2,
    DEC_FLOOR = 2'd3
  } dec_e;
endpackage

// File: rtl/fgov_window.sv
module fgov_window #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [PCT_W-1:0] thresh_i,
  output logic             win_end_o,
  output logic [WIN_W-1:0] busy_tot_o,
  output logic [WIN_W-1:0] len_o,
  output logic [PCT_W-1:0] pct_o,
  output logic [WIN_W-1:0] samp_cnt_o,
  output logic [WIN_W-1:0] busy_cnt_o
);
  function automatic logic [WIN_W-1:0] clamp_len(input logic [WIN_W-1:0] v);
    return (v == '0) ? WIN_W'(1) : v;
  endfunction

  logic             first_q;
  logic [WIN_W-1:0] len_q, cnt_q, bcnt_q;
  logic [PCT_W-1:0] pct_q;
  logic [WIN_W-1:0] len_eff, cnt_eff, bcnt_eff;
  logic [PCT_W-1:0] pct_eff;

  // A window's first edge takes fresh settings and restarts both counts.
  always_comb begin
    len_eff  = first_q ? clamp_len(win_len_i) : len_q;
    pct_eff  = first_q ? thresh_i : pct_q;
    cnt_eff  = first_q ? WIN_W'(1) : cnt_q + WIN_W'(1);
    bcnt_eff = (first_q ? '0 : bcnt_q) + {{(WIN_W-1){1'b0}}, busy_i};
  end

  assign win_end_o  = (cnt_eff == len_eff);
  assign busy_tot_o = bcnt_eff;
  assign len_o      = len_eff;
  assign pct_o      = pct_eff;
  assign samp_cnt_o = cnt_q;
  assign busy_cnt_o = bcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      len_q   <= '0;
      pct_q   <= '0;
      cnt_q   <= '0;
      bcnt_q  <= '0;
    end else begin
      first_q <= win_end_o;
      len_q   <= len_eff;
      pct_q   <= pct_eff;
      cnt_q   <= cnt_eff;
      bcnt_q  <= bcnt_eff;
    end
  end
endmodule

// File: rtl/fgov_util_cmp.sv
module fgov_util_cmp
  import fgov_pkg::*;
#(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned PCT_W = 7
) (
  input  logic [WIN_W-1:0] busy_tot_i,
  input  logic [WIN_W-1:0] len_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic             hot_o
);
  localparam int unsigned MUL_W  = (PCT_W > PCT_SCALE_W) ? PCT_W : PCT_SCALE_W;
  localparam int unsigned PROD_W = WIN_W + MUL_W + 1;

  // busy/len > pct/100 rewritten as two products
  function automatic logic over_threshold(input logic [WIN_W-1:0] busy,
                                          input logic [WIN_W-1:0] len,
                                          input logic [PCT_W-1:0] pct);
    logic [PROD_W-1:0] lhs, rhs;
    lhs = PROD_W'(busy) * PROD_W'(PCT_SCALE);
    rhs = PROD_W'(pct) * PROD_W'(len);
    return lhs > rhs;
  endfunction

  assign hot_o = over_threshold(busy_tot_i, len_i, pct_i);
endmodule

// File: rtl/fgov_level.sv
module fgov_level
  import fgov_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end_i,
  input  logic             hot_i,
  output logic [LVL_W-1:0] level_o,
  output logic             chg_o,
  output dec_e             dec_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS - 1);

  function automatic dec_e classify(input logic ends, input logic hot,
                                    input logic [LVL_W-1:0] cur);
    if (!ends)          return DEC_HOLD;
    else if (hot)       return DEC_JUMP;
    else if (cur == '0) return DEC_FLOOR;
    else                return DEC_STEP;
  endfunction

  function automatic logic [LVL_W-1:0] next_level(input dec_e d,
                                                  input logic [LVL_W-1:0] cur);
    case (d)
      DEC_JUMP: return TOP;
      DEC_STEP: return cur - LVL_W'(1);
      default:  return cur;
    endcase
  endfunction

  logic [LVL_W-1:0] lvl_q, lvl_nxt;

  assign dec_o   = classify(win_end_i, hot_i, lvl_q);
  assign lvl_nxt = next_level(dec_o, lvl_q);
  assign level_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= TOP;
      chg_o <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      chg_o <= (lvl_nxt != lvl_q);
    end
  end
endmodule

// File: rtl/util_freq_governor.sv
module util_freq_governor
  import fgov_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned PCT_W      = 7,
  localparam int unsigned LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [PCT_W-1:0] thresh_pct_i,
  output logic [LVL_W-1:0] level_o,
  output logic             level_chg_o
);
  logic             win_end;
  logic             win_hot;
  logic [WIN_W-1:0] busy_tot, win_len_eff, samp_cnt, busy_cnt;
  logic [PCT_W-1:0] pct_eff;
  dec_e             dec_kind;

  fgov_window #(.WIN_W(WIN_W), .PCT_W(PCT_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .win_len_i  (win_len_i),
    .thresh_i   (thresh_pct_i),
    .win_end_o  (win_end),
    .busy_tot_o (busy_tot),
    .len_o      (win_len_eff),
    .pct_o      (pct_eff),
    .samp_cnt_o (samp_cnt),
    .busy_cnt_o (busy_cnt)
  );

  fgov_util_cmp #(.WIN_W(WIN_W), .PCT_W(PCT_W)) u_cmp (
    .busy_tot_i (busy_tot),
    .len_i      (win_len_eff),
    .pct_i      (pct_eff),
    .hot_o      (win_hot)
  );

  fgov_level #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_end_i (win_end),
    .hot_i     (win_hot),
    .level_o   (level_o),
    .chg_o     (level_chg_o),
    .dec_o     (dec_kind)
  );
endmodule

// File: rtl/fgov_checker.sv
module fgov_checker
  import fgov_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] level,
  input logic             chg,
  input logic             win_end,
  input logic             win_hot,
  input logic [WIN_W-1:0] samp_cnt,
  input logic [WIN_W-1:0] busy_cnt,
  input dec_e             dec_kind
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS - 1);

  p_only_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(level));

  p_hot_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_hot) |=> (level == TOP));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_hot && level != '0) |=> (level == $past(level) - LVL_W'(1)));

  p_floor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_hot && level == '0) |=> (level == '0));

  p_strobe_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chg == (level != $past(level))));

  p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= samp_cnt);

  p_dec_only_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind != DEC_HOLD) == win_end);
endmodule

bind util_freq_governor fgov_checker #(
  .NUM_LEVELS(NUM_LEVELS), .WIN_W(WIN_W), .LVL_W(LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .level    (level_o),
  .chg      (level_chg_o),
  .win_end  (win_end),
  .win_hot  (win_hot),
  .samp_cnt (samp_cnt),
  .busy_cnt (busy_cnt),
  .dec_kind (dec_kind)
);

// File: tb/util_freq_governor_tb.sv
`timescale 1ns/1ps
module util_freq_governor_tb;
  localparam int NL    = 8;
  localparam int WW    = 16;
  localparam int PW    = 7;
  localparam int LW    = 3;
  localparam int TOPL  = NL - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy_i;
  logic [WW-1:0] win_len_i;
  logic [PW-1:0] thresh_pct_i;
  logic [LW-1:0] level_o;
  logic          level_chg_o;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_lvl = TOPL;

  always #2.5 clk = ~clk;

  util_freq_governor #(.NUM_LEVELS(NL), .WIN_W(WW), .PCT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .win_len_i(win_len_i),
    .thresh_pct_i(thresh_pct_i), .level_o(level_o), .level_chg_o(level_chg_o)
  );

  function automatic bit exp_hot(int busy, int len, int pct);
    longint diff;
    diff = longint'(busy) * 100 - longint'(pct) * longint'(len);
    return diff > 0;
  endfunction

  function automatic int exp_next(int cur, bit hot);
    if (hot) return TOPL;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; runs one full window.
  // mode 0: first nb samples busy; mode 1: each sample busy with nb percent chance.
  task automatic run_window(int len_drv, int pct, int nb, bit rnd, bit disturb);
    int le, busy_seen, prev;
    bit hot;
    string tag;
    le = (len_drv == 0) ? 1 : len_drv;
    busy_seen = 0;
    for (int i = 0; i < le; i++) begin
      if (rnd) busy_i = (($urandom % 100) < nb);
      else     busy_i = (i < nb);
      if (busy_i) busy_seen++;
      if (i == 0) begin
        win_len_i    = WW'(len_drv);
        thresh_pct_i = PW'(pct);
      end else if (disturb) begin
        win_len_i    = WW'($urandom % 8);
        thresh_pct_i = PW'($urandom % 101);
      end
      @(posedge clk);
      @(negedge clk);
      if (i < le - 1) begin
        chk("R2 level steady mid-window", int'(level_o), exp_lvl);
        chk("R6 no strobe mid-window", int'(level_chg_o), 0);
      end
    end
    hot  = exp_hot(busy_seen, le, pct);
    prev = exp_lvl;
    exp_lvl = exp_next(prev, hot);
    tag = hot ? "R3 jump to top" : ((prev == 0) ? "R5 floor hold" : "R4 step down");
    if (disturb) tag = {tag, " R7 settings captured"};
    chk(tag, int'(level_o), exp_lvl);
    chk("R6 strobe on change", int'(level_chg_o), (exp_lvl != prev) ? 1 : 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; busy_i = 1'b0; win_len_i = WW'(10); thresh_pct_i = PW'(90);
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(level_o), TOPL);
    chk("R1 reset strobe", int'(level_chg_o), 0);
    rst_n = 1'b1;

    run_window(10, 90, 10, 1'b0, 1'b0);  // R3 all busy stays on top, no strobe
    run_window(10, 90, 9, 1'b0, 1'b0);   // R4 exact tie steps down
    for (int k = 0; k < NL; k++)
      run_window(5, 50, 0, 1'b0, 1'b0);  // R5 walk to floor then hold
    run_window(4, 50, 3, 1'b0, 1'b0);    // R3 jump from floor
    run_window(0, 50, 1, 1'b0, 1'b0);    // R2 zero length behaves as one
    run_window(0, 50, 0, 1'b0, 1'b0);
    run_window(12, 40, 12, 1'b0, 1'b1);  // R7 disturbed settings
    run_window(12, 40, 4, 1'b0, 1'b1);
    run_window(20, 10, 20, 1'b0, 1'b0);  // R8 busy window then idle window
    run_window(20, 10, 0, 1'b0, 1'b0);
    run_window(1, 0, 1, 1'b0, 1'b0);     // R3 single-cycle hot window
    run_window(1, 100, 1, 1'b0, 1'b0);   // R4 100 percent never exceeded

    for (int w = 0; w < 300; w++)
      run_window(int'($urandom % 41), int'($urandom % 101),
                 int'($urandom % 101), 1'b1, ($urandom % 4) == 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule